// File: doc/BRIEF.md
# CPU Interrupt Delivery Unit

This block sits between the interrupt sources of a chip and one processor core. It takes three kinds of request: a reset request, a non-maskable interrupt (NMI) request, and a maskable interrupt level that is six bits wide. Each request that arrives is held as a pending request. The block then services pending requests only at instruction boundaries, which the core signals with a one-cycle strobe.

At each boundary the block services exactly one pending request, chosen by a fixed priority. Reset and NMI both lead to the same exception toward the core. A maskable level is first written into a six-bit cause field that the core can read. It is signalled as an interrupt exception only when the core's global interrupt enable is set and the level has at least one bit in common with the core's interrupt mask. If either check fails, the level stays pending and is tried again at every later boundary. A level of zero is an end-of-interrupt: it clears the cause field and drops the pending level without raising anything.

The exception request is a one-cycle pulse with a two-bit code. The core owns the status register, and the block only samples its enable and mask bits when it evaluates a request.

Top module: `irq_delivery_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `exc_valid_o` is 0, `exc_code_o` is 0 and `cause_ip_o` is 0, and no request is pending.
- R2: When several requests are pending at one boundary, only one is serviced. Reset is serviced first, then NMI, then the maskable level. The lower-priority requests stay pending for later boundaries.
- R3: Servicing a pending reset or a pending NMI clears that pending request. In the cycle after the boundary edge it drives `exc_valid_o`=1 and `exc_code_o`=2'b01.
- R4: Requests are evaluated only at a clock edge where `boundary_i` is 1. A request that arrives in the same cycle as a boundary is evaluated at the next boundary, not that one. No exception is raised while no request is pending.
- R5: When a pending nonzero level is evaluated, `cause_ip_o` takes that level in the cycle after the boundary edge. This happens whether or not the level is delivered. `cause_ip_o` changes at no other time.
- R6: A pending nonzero level is delivered only if `sr_ie_i` is 1 and (level & `sr_im_i`) is nonzero at the boundary. Delivery gives `exc_valid_o`=1 with `exc_code_o`=2'b10 and removes the pending level.
- R7: A nonzero level that fails the enable or mask check stays pending. It is evaluated again at every later boundary until it is delivered, cleared or replaced.
- R8: A level input of 0 (`lvl_vld_i`=1, `lvl_i`=0) is an end-of-interrupt. When it is evaluated, `cause_ip_o` becomes 0, the pending level is dropped and no exception is raised.
- R9: A new level that arrives while an older level is still pending replaces the older value.
- R10: Pending reset and NMI requests are held until they are serviced. While either one is pending, a pending level is not evaluated, so `cause_ip_o` is left unchanged at that boundary.
- R11: `exc_valid_o` is high only in the cycle after a boundary edge. `exc_code_o` is 2'b00 whenever `exc_valid_o` is 0 and is nonzero whenever `exc_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_req_i | input | 1 | One-cycle reset request from outside |
| nmi_req_i | input | 1 | One-cycle non-maskable interrupt request |
| lvl_vld_i | input | 1 | Marks a new maskable level on `lvl_i` |
| lvl_i | input | LVL_W | Maskable level; 0 means end-of-interrupt |
| boundary_i | input | 1 | Instruction-boundary strobe from the core |
| sr_ie_i | input | 1 | Current global interrupt enable from the status register |
| sr_im_i | input | LVL_W | Per-line interrupt mask from the status register |
| exc_valid_o | output | 1 | One-cycle exception request to the core |
| exc_code_o | output | 2 | 00 none, 01 NMI/reset, 10 interrupt |
| cause_ip_o | output | LVL_W | Hardware-interrupt field of the cause register |

## Verification
The hardest case to reach is a maskable level that keeps failing its check while other traffic goes on around it. To reach it, the bench leaves a level pending with the enable off, or with a mask that does not overlap the level, and applies several boundaries. It then sends a replacement level, or a zero level, before the request is finally allowed, so that both the retry and the overwrite are observed. A second hard case is a request that arrives in the same cycle as a boundary. The bench drives an NMI together with a boundary strobe and checks that the strobe produces nothing and that the next boundary services the NMI. Requests of all three kinds are also applied in one cycle, to walk through the priority order one boundary at a time.

// File: rtl/idu_pkg.sv
// Shared definitions for the interrupt delivery unit.
// Assumes: one core and one exception request per instruction boundary.
package idu_pkg;

    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        EXC_NONE   = 2'b00,
        EXC_NMIRST = 2'b01,
        EXC_INT    = 2'b10
    } exc_code_e;

endpackage

// File: rtl/idu_pending.sv
// Pending request store.
// Holds the sticky reset and NMI flags and the most recent maskable
// level. A request that arrives in the same cycle as a service clear
// wins, so that it is not lost.
// Assumes: the request inputs are one-cycle pulses that are already in
// the clock domain of this block.
module idu_pending #(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_req_i,
    input  logic             nmi_req_i,
    input  logic             lvl_vld_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             clr_rst_i,
    input  logic             clr_nmi_i,
    input  logic             clr_lvl_i,
    output logic             pend_rst_o,
    output logic             pend_nmi_o,
    output logic             pend_lvl_o,
    output logic [LVL_W-1:0] pend_lvl_val_o
);

    localparam int N_STICKY = 2;

    logic [N_STICKY-1:0] set_vec;
    logic [N_STICKY-1:0] clr_vec;
    logic [N_STICKY-1:0] flag_q;

    // Put the two sticky request sources side by side.
    always_comb begin
        set_vec = {nmi_req_i, rst_req_i};
        clr_vec = {clr_nmi_i, clr_rst_i};
    end

    // Reset and NMI flags work the same way, so build them in a loop.
    genvar g;
    generate
        for (g = 0; g < N_STICKY; g++) begin : g_sticky
            // Set on arrival and clear on service; arrival has priority.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flag_q[g] <= 1'b0;
                else if (set_vec[g])
                    flag_q[g] <= 1'b1;
                else if (clr_vec[g])
                    flag_q[g] <= 1'b0;
            end
        end
    endgenerate

    logic             lvl_pend_q;
    logic [LVL_W-1:0] lvl_val_q;

    // Pending level: a new value replaces the old one; it is dropped on
    // service unless a new value arrives in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_pend_q <= 1'b0;
            lvl_val_q  <= '0;
        end else if (lvl_vld_i) begin
            lvl_pend_q <= 1'b1;
            lvl_val_q  <= lvl_i;
        end else if (clr_lvl_i) begin
            lvl_pend_q <= 1'b0;
        end
    end

    // Drive the outputs from the stored state.
    always_comb begin
        pend_rst_o     = flag_q[0];
        pend_nmi_o     = flag_q[1];
        pend_lvl_o     = lvl_pend_q;
        pend_lvl_val_o = lvl_val_q;
    end

endmodule

// File: rtl/idu_arbiter.sv
// Boundary evaluator.
// At an instruction boundary it picks the pending request with the
// highest priority (reset, then NMI, then level). It works out the
// cause-field write, the enable and mask check, and which pending
// request to retire.
// Assumes: it is purely combinational, and its results are registered
// by the caller.
module idu_arbiter
    import idu_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             boundary_i,
    input  logic             pend_rst_i,
    input  logic             pend_nmi_i,
    input  logic             pend_lvl_i,
    input  logic [LVL_W-1:0] pend_lvl_val_i,
    input  logic             sr_ie_i,
    input  logic [LVL_W-1:0] sr_im_i,
    output logic             clr_rst_o,
    output logic             clr_nmi_o,
    output logic             clr_lvl_o,
    output logic             cause_wr_o,
    output logic [LVL_W-1:0] cause_val_o,
    output logic             fire_o,
    output exc_code_e        code_o
);

    logic lvl_is_eoi;
    logic lvl_allowed;

    // Classify the pending level: an end-of-interrupt, or whether it
    // passes the enable and mask check.
    always_comb begin
        lvl_is_eoi  = (pend_lvl_val_i == '0);
        lvl_allowed = sr_ie_i && ((pend_lvl_val_i & sr_im_i) != '0);
    end

    // Fixed-priority selection; at most one request is serviced.
    always_comb begin
        clr_rst_o   = 1'b0;
        clr_nmi_o   = 1'b0;
        clr_lvl_o   = 1'b0;
        cause_wr_o  = 1'b0;
        cause_val_o = '0;
        fire_o      = 1'b0;
        code_o      = EXC_NONE;
        if (boundary_i) begin
            if (pend_rst_i) begin
                clr_rst_o = 1'b1;
                fire_o    = 1'b1;
                code_o    = EXC_NMIRST;
            end else if (pend_nmi_i) begin
                clr_nmi_o = 1'b1;
                fire_o    = 1'b1;
                code_o    = EXC_NMIRST;
            end else if (pend_lvl_i) begin
                // The cause field is cleared and then loaded with the
                // level, which comes to writing the level itself.
                cause_wr_o  = 1'b1;
                cause_val_o = pend_lvl_val_i;
                if (lvl_is_eoi) begin
                    clr_lvl_o = 1'b1;
                end else if (lvl_allowed) begin
                    clr_lvl_o = 1'b1;
                    fire_o    = 1'b1;
                    code_o    = EXC_INT;
                end
            end
        end
    end

endmodule

// File: rtl/idu_out_stage.sv
// Output registers.
// Holds the cause hardware-interrupt field and turns the evaluator's
// decision into a one-cycle exception pulse with its code.
// Assumes: fire_i is high only in an evaluation cycle.
module idu_out_stage
    import idu_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cause_wr_i,
    input  logic [LVL_W-1:0] cause_val_i,
    input  logic             fire_i,
    input  exc_code_e        code_i,
    output logic             exc_valid_o,
    output exc_code_e        exc_code_o,
    output logic [LVL_W-1:0] cause_ip_o
);

    // Cause field: loaded only when a level is evaluated.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause_ip_o <= '0;
        else if (cause_wr_i)
            cause_ip_o <= cause_val_i;
    end

    // Exception pulse: follows the evaluator for one cycle at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_valid_o <= 1'b0;
            exc_code_o  <= EXC_NONE;
        end else begin
            exc_valid_o <= fire_i;
            exc_code_o  <= fire_i ? code_i : EXC_NONE;
        end
    end

endmodule

// File: rtl/irq_delivery_unit.sv
// Interrupt delivery unit (top).
// Latches reset, NMI and maskable-level requests and evaluates them at
// instruction boundaries. It updates the cause interrupt field and
// raises a one-cycle exception request toward a single core.
// Assumes: the core supplies a one-cycle boundary strobe and the live
// status-register enable and mask bits.
module irq_delivery_unit
    import idu_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_req_i,
    input  logic              nmi_req_i,
    input  logic              lvl_vld_i,
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic              boundary_i,
    input  logic              sr_ie_i,
    input  logic [LVL_W-1:0]  sr_im_i,
    output logic              exc_valid_o,
    output logic [CODE_W-1:0] exc_code_o,
    output logic [LVL_W-1:0]  cause_ip_o
);

    logic             pend_rst;
    logic             pend_nmi;
    logic             pend_lvl;
    logic [LVL_W-1:0] pend_lvl_val;
    logic             clr_rst;
    logic             clr_nmi;
    logic             clr_lvl;
    logic             cause_wr;
    logic [LVL_W-1:0] cause_val;
    logic             fire;
    exc_code_e        fire_code;
    exc_code_e        code_q;

    idu_pending #(.LVL_W(LVL_W)) u_pending (
        .clk            (clk),
        .rst_n          (rst_n),
        .rst_req_i      (rst_req_i),
        .nmi_req_i      (nmi_req_i),
        .lvl_vld_i      (lvl_vld_i),
        .lvl_i          (lvl_i),
        .clr_rst_i      (clr_rst),
        .clr_nmi_i      (clr_nmi),
        .clr_lvl_i      (clr_lvl),
        .pend_rst_o     (pend_rst),
        .pend_nmi_o     (pend_nmi),
        .pend_lvl_o     (pend_lvl),
        .pend_lvl_val_o (pend_lvl_val)
    );

    idu_arbiter #(.LVL_W(LVL_W)) u_arbiter (
        .boundary_i     (boundary_i),
        .pend_rst_i     (pend_rst),
        .pend_nmi_i     (pend_nmi),
        .pend_lvl_i     (pend_lvl),
        .pend_lvl_val_i (pend_lvl_val),
        .sr_ie_i        (sr_ie_i),
        .sr_im_i        (sr_im_i),
        .clr_rst_o      (clr_rst),
        .clr_nmi_o      (clr_nmi),
        .clr_lvl_o      (clr_lvl),
        .cause_wr_o     (cause_wr),
        .cause_val_o    (cause_val),
        .fire_o         (fire),
        .code_o         (fire_code)
    );

    idu_out_stage #(.LVL_W(LVL_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .cause_wr_i  (cause_wr),
        .cause_val_i (cause_val),
        .fire_i      (fire),
        .code_i      (fire_code),
        .exc_valid_o (exc_valid_o),
        .exc_code_o  (code_q),
        .cause_ip_o  (cause_ip_o)
    );

    // Present the enumerated code on a plain vector port.
    always_comb exc_code_o = code_q;

endmodule

// File: rtl/idu_chk.sv
// Assertion checker for irq_delivery_unit, attached with bind.
// Assumes: it observes the ports of the top module only.
module idu_chk #(
    parameter int LVL_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             boundary_i,
    input logic             sr_ie_i,
    input logic [LVL_W-1:0] sr_im_i,
    input logic             exc_valid_o,
    input logic [1:0]       exc_code_o,
    input logic [LVL_W-1:0] cause_ip_o
);

    // R11
    pulse_needs_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_o |-> (exc_code_o != 2'b00));

    // R11
    idle_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid_o |-> (exc_code_o == 2'b00));

    // R4
    pulse_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_o |-> $past(boundary_i));

    // R5
    cause_only_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(boundary_i) |-> $stable(cause_ip_o));

    // R6
    int_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_o && exc_code_o == 2'b10) |->
            ($past(sr_ie_i) && ((cause_ip_o & $past(sr_im_i)) != '0)));

endmodule

bind irq_delivery_unit idu_chk #(.LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .boundary_i  (boundary_i),
    .sr_ie_i     (sr_ie_i),
    .sr_im_i     (sr_im_i),
    .exc_valid_o (exc_valid_o),
    .exc_code_o  (exc_code_o),
    .cause_ip_o  (cause_ip_o)
);

// File: tb/irq_delivery_unit_tb.sv
// Scoreboard bench for irq_delivery_unit. Each boundary pushes one
// expected result, and a monitor compares it one cycle later.
module irq_delivery_unit_tb;

    localparam int LVL_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rst_req = 1'b0;
    logic             nmi_req = 1'b0;
    logic             lvl_vld = 1'b0;
    logic [LVL_W-1:0] lvl = '0;
    logic             boundary = 1'b0;
    logic             sr_ie = 1'b1;
    logic [LVL_W-1:0] sr_im = '1;
    logic             exc_valid;
    logic [1:0]       exc_code;
    logic [LVL_W-1:0] cause_ip;

    int n_chk = 0;
    int n_err = 0;
    logic bnd_seen = 1'b0;

    typedef struct {
        logic             v;
        logic [1:0]       c;
        logic [LVL_W-1:0] ip;
        string            tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t cur;

    always #4 clk = ~clk;

    irq_delivery_unit #(.LVL_W(LVL_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_req_i   (rst_req),
        .nmi_req_i   (nmi_req),
        .lvl_vld_i   (lvl_vld),
        .lvl_i       (lvl),
        .boundary_i  (boundary),
        .sr_ie_i     (sr_ie),
        .sr_im_i     (sr_im),
        .exc_valid_o (exc_valid),
        .exc_code_o  (exc_code),
        .cause_ip_o  (cause_ip)
    );

    // Remember which edges were boundary edges.
    always @(posedge clk) bnd_seen <= rst_n && boundary;

    // Monitor: after a boundary edge, pop the expected item and compare.
    // On any other cycle, check that no exception pulse is present.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bnd_seen) begin
                n_chk++;
                if (sb_q.size() == 0) begin
                    n_err++;
                    $display("FAIL scoreboard empty: actual v=%0b expected item", exc_valid);
                end else begin
                    cur = sb_q.pop_front();
                    if (exc_valid !== cur.v || exc_code !== cur.c || cause_ip !== cur.ip) begin
                        n_err++;
                        $display("FAIL %s: actual v=%0b code=%0d ip=%h expected v=%0b code=%0d ip=%h",
                                 cur.tag, exc_valid, exc_code, cause_ip, cur.v, cur.c, cur.ip);
                    end
                end
            end else begin
                n_chk++;
                if (exc_valid !== 1'b0 || exc_code !== 2'b00) begin
                    n_err++;
                    $display("FAIL R11 no pulse off-boundary: actual v=%0b code=%0d expected v=0 code=0",
                             exc_valid, exc_code);
                end
            end
        end
    end

    // Pulse any combination of request inputs for one cycle.
    task automatic req(input logic r, input logic n, input logic lv, input logic [LVL_W-1:0] l);
        @(negedge clk);
        rst_req = r; nmi_req = n; lvl_vld = lv; lvl = l;
        @(negedge clk);
        rst_req = 0; nmi_req = 0; lvl_vld = 0; lvl = '0;
    endtask

    // Apply one boundary and push its expected result.
    task automatic bnd(input logic v, input logic [1:0] c, input logic [LVL_W-1:0] ip, input string tag);
        exp_t e;
        e.v = v; e.c = c; e.ip = ip; e.tag = tag;
        @(negedge clk);
        sb_q.push_back(e);
        boundary = 1;
        @(negedge clk);
        boundary = 0;
    endtask

    // Boundary with an NMI arriving in the same cycle.
    task automatic bnd_with_nmi(input logic [LVL_W-1:0] ip, input string tag);
        exp_t e;
        e.v = 0; e.c = 2'b00; e.ip = ip; e.tag = tag;
        @(negedge clk);
        sb_q.push_back(e);
        boundary = 1; nmi_req = 1;
        @(negedge clk);
        boundary = 0; nmi_req = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (exc_valid !== 0 || exc_code !== 0 || cause_ip !== 0) begin
            n_err++;
            $display("FAIL R1 in reset: actual v=%0b code=%0d ip=%h expected 0 0 00", exc_valid, exc_code, cause_ip);
        end
        rst_n = 1;
        @(negedge clk);
        n_chk++;
        if (exc_valid !== 0 || exc_code !== 0 || cause_ip !== 0) begin
            n_err++;
            $display("FAIL R1 after reset: actual v=%0b code=%0d ip=%h expected 0 0 00", exc_valid, exc_code, cause_ip);
        end
        bnd(0, 2'b00, 6'h00, "R1 nothing pending");

        // R3: NMI, then reset; both give code 01.
        req(0, 1, 0, 0);
        repeat (3) @(negedge clk);
        bnd(1, 2'b01, 6'h00, "R3 nmi serviced");
        req(1, 0, 0, 0);
        bnd(1, 2'b01, 6'h00, "R3 reset serviced");
        bnd(0, 2'b00, 6'h00, "R3 flag cleared");

        // R2: all three in one cycle.
        req(1, 1, 1, 6'h05);
        bnd(1, 2'b01, 6'h00, "R2 reset first");
        bnd(1, 2'b01, 6'h00, "R2 nmi second");
        bnd(1, 2'b10, 6'h05, "R2 level third");

        // R4: NMI arriving with a boundary waits for the next one.
        bnd_with_nmi(6'h05, "R4 same-cycle nmi not evaluated");
        bnd(1, 2'b01, 6'h05, "R4 nmi at next boundary");

        // R8: end-of-interrupt clears cause without an exception.
        req(0, 0, 1, 6'h00);
        bnd(0, 2'b00, 6'h00, "R8 eoi clears cause");

        // R7 and R6: a masked level is retried until allowed.
        sr_ie = 0;
        req(0, 0, 1, 6'h04);
        bnd(0, 2'b00, 6'h04, "R5 cause written while disabled");
        bnd(0, 2'b00, 6'h04, "R7 retry disabled");
        sr_ie = 1; sr_im = 6'h03;
        bnd(0, 2'b00, 6'h04, "R7 retry masked");
        sr_im = 6'h04;
        bnd(1, 2'b10, 6'h04, "R6 delivered when unmasked");
        bnd(0, 2'b00, 6'h04, "R6 pending dropped");

        // R9: a newer level replaces an older one.
        sr_ie = 0; sr_im = '1;
        req(0, 0, 1, 6'h02);
        req(0, 0, 1, 6'h08);
        sr_ie = 1;
        bnd(1, 2'b10, 6'h08, "R9 newer level wins");
        bnd(0, 2'b00, 6'h08, "R9 nothing left");

        // R8: end-of-interrupt cancels a masked pending level.
        sr_ie = 0;
        req(0, 0, 1, 6'h01);
        bnd(0, 2'b00, 6'h01, "R7 held while disabled");
        req(0, 0, 1, 6'h00);
        sr_ie = 1;
        bnd(0, 2'b00, 6'h00, "R8 eoi over pending level");
        bnd(0, 2'b00, 6'h00, "R8 level dropped");

        // R10: NMI holds off a level; cause untouched meanwhile.
        req(0, 1, 1, 6'h10);
        bnd(1, 2'b01, 6'h00, "R10 nmi ahead, cause kept");
        bnd(1, 2'b10, 6'h10, "R10 level after nmi");

        // R11: back-to-back boundaries give separate pulses.
        req(1, 1, 0, 0);
        bnd(1, 2'b01, 6'h10, "R11 first pulse");
        bnd(1, 2'b01, 6'h10, "R11 second pulse");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_chk++; n_err++;
            $display("FAIL scoreboard leftover: actual=%0d expected=0", sb_q.size());
        end
        summary();
        $finish;
    end

endmodule